// File: doc/BRIEF.md
# Print-Line Echo Interleave Sequencer

This block collects one print line from a word-oriented data channel into a line buffer. The buffer holds twelve card rows of two 36-bit words each, 24 words in all. A start command selects two options. Normal or binary addressing sets which buffer word is filled first. Plain printing or echo checking sets how the line is sequenced. A step timer paces the whole line. It has programmable cycle counts for line start, line stop, short steps and long steps.

In plain printing, every channel word goes straight into the buffer at a running pointer. The line closes on an end-of-record flag, when the last word of the addressing mode is written, or when the channel disconnects. In echo checking, the controller runs a fixed schedule of 46 steps. Write steps take a channel word. Read steps return an echo word to the channel. The echo words are built from the buffer when they are needed: row 8 AND row 4, row 8 AND row 3, or a plain copy of a digit row. After a line ends, the controller waits out the stop delay. It then starts the next line in the same modes if the channel is still connected, and goes idle if it is not. A print stage downstream reads the finished line through a word read port.

Top module: `print_echo_seq`

## Requirements
- R1: After reset the controller is idle. stall_o, wr_req_o, rd_valid_o, line_done_o and io_check_o are low, and every buffer word reads zero.
- R2: A start command is accepted only while idle, and accepting it clears io_check_o. A start while busy raises stall_o for one cycle and leaves the current line unchanged.
- R3: Before the first step of a line, all 24 buffer words are cleared. Buffer index = 2*row_position + half, where the row order is 9,8,7,6,5,4,3,2,1,0,11,12. The first word goes to index 16 (row 1) in binary mode and to index 0 in normal mode.
- R4: In plain printing, the k-th channel word is stored at the first index plus k. The line ends with a one-cycle line_done_o pulse when a word carries end-of-record, or when the word at index 17 (binary) or index 23 (normal) is written.
- R5: In plain printing, a step that finds chan_conn_i low ends the line.
- R6: In echo checking, step p runs from the first index up to 45. Steps 0-17, 20-21, 24-25 and 28-29 are writes, to buffer indices p, p-2, p-4 and p-6 respectively. Steps 18-19, 22-23, 26-27 and 30-45 are reads of echo indices p-18, p-20, p-22 and p-24. A write request is issued ahead of each write step, and the line ends after step 45.
- R7: Echo indices 0-1 return buffer[2+e] AND buffer[10+e]. Indices 2-3 return buffer[e] AND buffer[10+e]. Index e of 4 or more returns buffer[e-4].
- R8: A write step with no fresh channel word sets the sticky io_check_o and stores the last word received. The channel's valid mark is consumed by each step.
- R9: After an echo read step, or a step that leaves the pointer odd, the next step follows T_SHORT+1 cycles later. After a write step that leaves the pointer even, it follows T_LONG+1 cycles later.
- R10: After a line ends, the controller restarts a new line in the same modes once the stop delay has passed, if chan_conn_i is high. Otherwise it goes idle.
- R11: buf_word_o returns the buffer word at buf_idx_i, and zero for an index of 24 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start-line command |
| start_bin_i | input | 1 | Binary addressing for the commanded line |
| start_echo_i | input | 1 | Echo checking for the commanded line |
| stall_o | output | 1 | Start rejected because busy |
| chan_conn_i | input | 1 | Channel still connected |
| wr_valid_i | input | 1 | Channel word strobe |
| wr_data_i | input | 36 | Channel word |
| wr_eor_i | input | 1 | End-of-record with the word |
| wr_req_o | output | 1 | Request for the next channel word |
| rd_valid_o | output | 1 | Echo word strobe |
| rd_data_o | output | 36 | Echo word |
| io_check_o | output | 1 | Sticky missing-word flag |
| line_done_o | output | 1 | Line finished pulse |
| buf_idx_i | input | 5 | Buffer read index |
| buf_word_o | output | 36 | Buffer read word |

## Verification
Assertions cover several things on every cycle. Echo strobes appear only out of an echo step. A finished line always lands in the end state. The step pointer stays inside the schedule or the addressing limit. io_check_o stays set until a new start, and an idle start always enters initialisation. Only the bench scenarios can show the rest: the word values in the buffer, the exact interleave and the contents of the echo words, the stale-word store after a skipped request, the step spacing, and the automatic restart compared with going idle.

// File: rtl/pe_pkg.sv
package pe_pkg;
  localparam int WORD_W     = 36;
  localparam int LINE_WORDS = 24;
  localparam int STEP_CNT   = 46;
  localparam int IDX_W      = $clog2(LINE_WORDS);
  localparam int PTR_W      = $clog2(STEP_CNT + 1);

  localparam logic [IDX_W-1:0] ROW8_AT = IDX_W'(2);
  localparam logic [IDX_W-1:0] ROW4_AT = IDX_W'(10);
  localparam logic [IDX_W-1:0] ROW3_AT = IDX_W'(12);
  localparam logic [PTR_W-1:0] BIN_FIRST = PTR_W'(16);
  localparam logic [PTR_W-1:0] BIN_LAST  = PTR_W'(17);
  localparam logic [PTR_W-1:0] NRM_LAST  = PTR_W'(23);

  typedef enum logic [1:0] {
    ST_INIT  = 2'd0,
    ST_PRINT = 2'd1,
    ST_ECHO  = 2'd2,
    ST_END   = 2'd3
  } pe_state_e;

  typedef struct packed {
    logic             echo;
    logic [IDX_W-1:0] idx;
  } pe_step_t;

  // interleave schedule: write/echo blocks and their index offsets
  function automatic pe_step_t step_of(input logic [PTR_W-1:0] p);
    pe_step_t s;
    logic [PTR_W-1:0] t;
    s.echo = 1'b1;
    t      = p - PTR_W'(24);
    if (p < PTR_W'(18))      begin s.echo = 1'b0; t = p;               end
    else if (p < PTR_W'(20)) begin s.echo = 1'b1; t = p - PTR_W'(18); end
    else if (p < PTR_W'(22)) begin s.echo = 1'b0; t = p - PTR_W'(2);  end
    else if (p < PTR_W'(24)) begin s.echo = 1'b1; t = p - PTR_W'(20); end
    else if (p < PTR_W'(26)) begin s.echo = 1'b0; t = p - PTR_W'(4);  end
    else if (p < PTR_W'(28)) begin s.echo = 1'b1; t = p - PTR_W'(22); end
    else if (p < PTR_W'(30)) begin s.echo = 1'b0; t = p - PTR_W'(6);  end
    s.idx = t[IDX_W-1:0];
    return s;
  endfunction

  function automatic logic step_is_echo(input logic [PTR_W-1:0] p);
    pe_step_t s;
    s = step_of(p);
    return s.echo;
  endfunction
endpackage

// File: rtl/pe_step_timer.sv
module pe_step_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/pe_line_buf.sv
module pe_line_buf
  import pe_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int N  = LINE_WORDS,
  parameter int AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] echo_idx_i,
  output logic [W-1:0]  echo_word_o,
  input  logic [AW-1:0] rd_idx_i,
  output logic [W-1:0]  rd_word_o
);
  logic [W-1:0] mem [N];

  for (genvar g = 0; g < N; g++) begin : g_word
    logic [W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             q <= '0;
      else if (clr_i)                          q <= '0;
      else if (we_i && waddr_i == AW'(g))      q <= wdata_i;
    end
    assign mem[g] = q;
  end

  // echo words derived from live buffer; rows 9..1 are final before first echo
  logic [AW-1:0] and_a, and_b;
  always_comb begin
    and_a = AW'(ROW8_AT) + AW'(echo_idx_i[0]);
    and_b = (echo_idx_i[1] ? AW'(ROW3_AT) : AW'(ROW4_AT)) + AW'(echo_idx_i[0]);
    if (echo_idx_i < AW'(4)) echo_word_o = mem[and_a] & mem[and_b];
    else                     echo_word_o = mem[echo_idx_i - AW'(4)];
  end

  assign rd_word_o = (rd_idx_i < AW'(N)) ? mem[rd_idx_i] : '0;
endmodule

// File: rtl/print_echo_seq.sv
module print_echo_seq
  import pe_pkg::*;
#(
  parameter int T_START = 4,
  parameter int T_STOP  = 6,
  parameter int T_SHORT = 3,
  parameter int T_LONG  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              start_bin_i,
  input  logic              start_echo_i,
  output logic              stall_o,
  input  logic              chan_conn_i,
  input  logic              wr_valid_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              wr_eor_i,
  output logic              wr_req_o,
  output logic              rd_valid_o,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              io_check_o,
  output logic              line_done_o,
  input  logic [IDX_W-1:0]  buf_idx_i,
  output logic [WORD_W-1:0] buf_word_o
);
  localparam int T_MAX01 = (T_START > T_STOP) ? T_START : T_STOP;
  localparam int T_MAX23 = (T_SHORT > T_LONG) ? T_SHORT : T_LONG;
  localparam int T_MAX   = (T_MAX01 > T_MAX23) ? T_MAX01 : T_MAX23;
  localparam int CNT_W   = $clog2(T_MAX + 1);
  localparam logic [CNT_W-1:0] D_START = CNT_W'(T_START);
  localparam logic [CNT_W-1:0] D_STOP  = CNT_W'(T_STOP);
  localparam logic [CNT_W-1:0] D_SHORT = CNT_W'(T_SHORT);
  localparam logic [CNT_W-1:0] D_LONG  = CNT_W'(T_LONG);

  pe_state_e         state_q, state_d;
  logic              active_q, active_d;
  logic              bin_q, bin_d, echo_q, echo_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d, nxt_ptr, limit;
  logic [WORD_W-1:0] hold_q, hold_d;
  logic              hold_v_q, hold_v_d;
  logic              ioc_q, ioc_d;
  logic              wr_req_q, wr_req_d, rd_v_q, rd_v_d, done_q, done_d, stall_q, stall_d;
  logic [WORD_W-1:0] rd_d_q, rd_d_d;

  logic              t_load, t_zero;
  logic [CNT_W-1:0]  t_val;
  logic              buf_clr, buf_we;
  logic [IDX_W-1:0]  buf_waddr;
  logic [WORD_W-1:0] buf_wdata, echo_word;
  pe_step_t          cur;
  logic              start_ok, wr_take, pr_wr, fire;

  pe_step_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .load_i(t_load), .val_i (t_val), .zero_o(t_zero)
  );

  pe_line_buf #(.W(WORD_W), .N(LINE_WORDS)) u_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (buf_clr),
    .we_i       (buf_we),
    .waddr_i    (buf_waddr),
    .wdata_i    (buf_wdata),
    .echo_idx_i (cur.idx),
    .echo_word_o(echo_word),
    .rd_idx_i   (buf_idx_i),
    .rd_word_o  (buf_word_o)
  );

  assign cur      = step_of(ptr_q);
  assign nxt_ptr  = ptr_q + 1'b1;
  assign limit    = bin_q ? BIN_LAST : NRM_LAST;
  assign start_ok = start_i && !active_q;
  assign wr_take  = wr_valid_i && active_q && (state_q == ST_PRINT || state_q == ST_ECHO);
  assign pr_wr    = wr_take && (state_q == ST_PRINT);
  assign fire     = active_q && t_zero;

  always_comb begin
    state_d  = state_q;  active_d = active_q;
    bin_d    = bin_q;    echo_d   = echo_q;
    ptr_d    = ptr_q;    ioc_d    = ioc_q;
    hold_d   = hold_q;   hold_v_d = hold_v_q;
    rd_d_d   = rd_d_q;
    wr_req_d = 1'b0;     rd_v_d   = 1'b0;
    done_d   = 1'b0;     stall_d  = start_i && active_q;
    t_load   = 1'b0;     t_val    = '0;
    buf_clr  = 1'b0;     buf_we   = 1'b0;
    buf_waddr = ptr_q[IDX_W-1:0];
    buf_wdata = wr_data_i;

    if (wr_take) begin
      hold_d   = wr_data_i;
      hold_v_d = 1'b1;
    end

    if (start_ok) begin
      state_d  = ST_INIT;
      active_d = 1'b1;
      bin_d    = start_bin_i;
      echo_d   = start_echo_i;
      ioc_d    = 1'b0;
      t_load   = 1'b1;
      t_val    = D_START;
    end else if (pr_wr) begin
      // word written on arrival; may close the line
      buf_we = 1'b1;
      ptr_d  = nxt_ptr;
      if (wr_eor_i || ptr_q >= limit) begin
        state_d = ST_END; done_d = 1'b1; t_load = 1'b1; t_val = D_STOP;
      end
    end else if (fire) begin
      unique case (state_q)
        ST_INIT: begin
          buf_clr  = 1'b1;
          ptr_d    = bin_q ? BIN_FIRST : '0;
          state_d  = echo_q ? ST_ECHO : ST_PRINT;
          hold_v_d = 1'b0;
          wr_req_d = 1'b1;
          t_load   = 1'b1;
          t_val    = D_SHORT;
        end
        ST_PRINT: begin
          t_load = 1'b1;
          if (!chan_conn_i) begin
            state_d = ST_END; done_d = 1'b1; t_val = D_STOP;
          end else begin
            if (!hold_v_q) ioc_d = 1'b1;
            hold_v_d = 1'b0;
            wr_req_d = 1'b1;
            t_val    = ptr_q[0] ? D_SHORT : D_LONG;
          end
        end
        ST_ECHO: begin
          ptr_d  = nxt_ptr;
          t_load = 1'b1;
          if (cur.echo) begin
            rd_v_d = 1'b1;
            rd_d_d = echo_word;
            if (nxt_ptr >= PTR_W'(STEP_CNT)) begin
              state_d = ST_END; done_d = 1'b1; t_val = D_STOP;
            end else begin
              t_val = D_SHORT;
            end
          end else begin
            buf_we    = 1'b1;
            buf_waddr = cur.idx;
            buf_wdata = hold_q;
            if (!hold_v_q) ioc_d = 1'b1;
            hold_v_d  = wr_take;
            t_val     = nxt_ptr[0] ? D_SHORT : D_LONG;
          end
          if (nxt_ptr < PTR_W'(STEP_CNT) && !step_is_echo(nxt_ptr)) wr_req_d = 1'b1;
        end
        ST_END: begin
          if (chan_conn_i) begin
            state_d = ST_INIT; t_load = 1'b1; t_val = '0;
          end else begin
            active_d = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_INIT; active_q <= 1'b0;
      bin_q    <= 1'b0;    echo_q   <= 1'b0;
      ptr_q    <= '0;      ioc_q    <= 1'b0;
      hold_q   <= '0;      hold_v_q <= 1'b0;
      wr_req_q <= 1'b0;    rd_v_q   <= 1'b0;
      rd_d_q   <= '0;      done_q   <= 1'b0;
      stall_q  <= 1'b0;
    end else begin
      state_q  <= state_d;  active_q <= active_d;
      bin_q    <= bin_d;    echo_q   <= echo_d;
      ptr_q    <= ptr_d;    ioc_q    <= ioc_d;
      hold_q   <= hold_d;   hold_v_q <= hold_v_d;
      wr_req_q <= wr_req_d; rd_v_q   <= rd_v_d;
      rd_d_q   <= rd_d_d;   done_q   <= done_d;
      stall_q  <= stall_d;
    end
  end

  assign stall_o     = stall_q;
  assign wr_req_o    = wr_req_q;
  assign rd_valid_o  = rd_v_q;
  assign rd_data_o   = rd_d_q;
  assign io_check_o  = ioc_q;
  assign line_done_o = done_q;

  AST_START_FROM_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !active_q) |=> (active_q && state_q == ST_INIT && !stall_o)); // R2
  AST_DONE_IN_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_done_o |-> (state_q == ST_END)); // R4
  AST_PRINT_PTR_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && state_q == ST_PRINT) |-> (ptr_q <= limit)); // R4
  AST_ECHO_PTR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && state_q == ST_ECHO) |-> (ptr_q < PTR_W'(STEP_CNT))); // R6
  AST_READ_FROM_ECHO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> ($past(state_q) == ST_ECHO)); // R6
  AST_IOC_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_check_o && !start_i) |=> io_check_o); // R8
endmodule

// File: tb/print_echo_seq_tb.sv
`timescale 1ns/100ps
module print_echo_seq_tb;
  localparam int TS = 4, TP = 6, TSH = 3, TL = 5;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        start_i = 0, start_bin_i = 0, start_echo_i = 0;
  logic        chan_conn_i = 0, wr_valid_i = 0, wr_eor_i = 0;
  logic [35:0] wr_data_i = '0;
  logic [4:0]  buf_idx_i = '0;
  logic        stall_o, wr_req_o, rd_valid_o, io_check_o, line_done_o;
  logic [35:0] rd_data_o, buf_word_o;

  print_echo_seq #(.T_START(TS), .T_STOP(TP), .T_SHORT(TSH), .T_LONG(TL)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .start_bin_i(start_bin_i),
    .start_echo_i(start_echo_i), .stall_o(stall_o), .chan_conn_i(chan_conn_i),
    .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i), .wr_eor_i(wr_eor_i),
    .wr_req_o(wr_req_o), .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o),
    .io_check_o(io_check_o), .line_done_o(line_done_o),
    .buf_idx_i(buf_idx_i), .buf_word_o(buf_word_o)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  logic [35:0] sent_log [64];
  logic [35:0] store_log[64];
  logic [35:0] rd_log   [64];
  int          rd_time  [64];
  int          req_time [64];
  int          nsent, nreq, nrd;
  bit          done_seen;
  logic [35:0] last_w = '0;
  logic [35:0] exp_buf  [24];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] rnd_word();
    logic [63:0] t;
    t = {$urandom(), $urandom()};
    return t[35:0];
  endfunction

  function automatic bit tb_is_echo(input int p);
    return (p >= 18 && p < 20) || (p >= 22 && p < 24) || (p >= 26 && p < 28) || (p >= 30);
  endfunction

  function automatic int tb_idx(input int p);
    if (p < 18) return p;
    if (p < 20) return p - 18;
    if (p < 22) return p - 2;
    if (p < 24) return p - 20;
    if (p < 26) return p - 4;
    if (p < 28) return p - 22;
    if (p < 30) return p - 6;
    return p - 24;
  endfunction

  task automatic drive_line(input bit do_start, input bit bin, input bit echo,
                            input int skip_req, input int eor_word, input int drop_after,
                            input int stall_k, input bit keep_conn);
    nsent = 0; nreq = 0; nrd = 0; done_seen = 0;
    if (do_start) begin
      @(negedge clk);
      chan_conn_i = 1; start_bin_i = bin; start_echo_i = echo; start_i = 1;
    end
    for (int k = 0; k < 4000 && !done_seen; k++) begin
      @(negedge clk);
      if (do_start && k == 0) chk(stall_o == 1'b0, "R2 idle start accepted", stall_o, 0);
      if (k == stall_k + 1)   chk(stall_o == 1'b1, "R2 busy start stalls", stall_o, 1);
      start_i = 0; wr_valid_i = 0; wr_eor_i = 0;
      if (rd_valid_o) begin
        rd_log[nrd] = rd_data_o; rd_time[nrd] = cyc; nrd++;
      end
      if (wr_req_o) begin
        req_time[nreq] = cyc;
        if (nreq != skip_req) begin
          logic [35:0] w;
          w = rnd_word();
          wr_data_i = w; wr_valid_i = 1; wr_eor_i = (nsent == eor_word);
          sent_log[nsent] = w; last_w = w; nsent++;
        end
        store_log[nreq] = last_w; nreq++;
      end
      if (drop_after > 0 && nsent == drop_after) chan_conn_i = 0;
      if (k == stall_k) begin
        start_i = 1; start_bin_i = ~bin; start_echo_i = ~echo;
      end
      if (line_done_o) begin
        done_seen = 1;
        if (!keep_conn) chan_conn_i = 0;
      end
    end
    chk(done_seen, "R4 line completes", done_seen, 1);
  endtask

  task automatic build_exp(input bit bin, input bit echo);
    int base, r;
    base = bin ? 16 : 0;
    for (int i = 0; i < 24; i++) exp_buf[i] = '0;
    if (!echo) begin
      for (int k = 0; k < nsent; k++) exp_buf[base + k] = sent_log[k];
    end else begin
      r = 0;
      for (int p = base; p < 46; p++)
        if (!tb_is_echo(p)) begin exp_buf[tb_idx(p)] = store_log[r]; r++; end
    end
  endtask

  task automatic check_buf(input bit bin, input bit echo, input string req);
    build_exp(bin, echo);
    for (int i = 0; i < 24; i++) begin
      buf_idx_i = 5'(i);
      #0.5;
      chk(buf_word_o === exp_buf[i], req, buf_word_o, exp_buf[i]);
    end
  endtask

  task automatic check_echo(input bit bin);
    int base, j, e, nw;
    logic [35:0] v;
    base = bin ? 16 : 0;
    build_exp(bin, 1'b1);
    j = 0; nw = 0;
    for (int p = base; p < 46; p++) begin
      if (tb_is_echo(p)) begin
        e = tb_idx(p);
        if (e < 2)      v = exp_buf[2 + e] & exp_buf[10 + e];
        else if (e < 4) v = exp_buf[e] & exp_buf[10 + e];
        else            v = exp_buf[e - 4];
        chk(rd_log[j] === v, "R7 echo word value/order", rd_log[j], v);
        j++;
      end else nw++;
    end
    chk(nrd == 22, "R6 echo read count", nrd, 22);
    chk(nreq == nw, "R6 write request count", nreq, nw);
  endtask

  task automatic idle_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    chk(stall_o == 0,     "R1 stall low",    stall_o, 0);
    chk(wr_req_o == 0,    "R1 req low",      wr_req_o, 0);
    chk(rd_valid_o == 0,  "R1 read low",     rd_valid_o, 0);
    chk(line_done_o == 0, "R1 done low",     line_done_o, 0);
    chk(io_check_o == 0,  "R1 check low",    io_check_o, 0);
    buf_idx_i = 5'd23; #0.5;
    chk(buf_word_o == 0,  "R1 buffer zero",  buf_word_o, 0);
    buf_idx_i = 5'd30; #0.5;
    chk(buf_word_o == 0,  "R11 out-of-range index", buf_word_o, 0);

    // normal print line with a busy start; connection kept for restart
    drive_line(1, 0, 0, 999, -1, 0, 8, 1);
    chk(nsent == 24, "R4 normal line length", nsent, 24);
    chk(req_time[2] - req_time[1] == TSH + 1, "R9 odd pointer short step", req_time[2] - req_time[1], TSH + 1);
    chk(req_time[3] - req_time[2] == TL + 1,  "R9 even pointer long step", req_time[3] - req_time[2], TL + 1);
    chk(io_check_o == 0, "R8 no check when fed", io_check_o, 0);
    check_buf(0, 0, "R2 R4 R11 normal line stored");
    // R10 automatic restart, then R5 connection loss after 3 words
    drive_line(0, 0, 0, 999, -1, 3, 10000, 0);
    chk(nsent == 3, "R5 R10 restarted line cut by disconnect", nsent, 3);
    check_buf(0, 0, "R3 R5 buffer cleared then partial");
    idle_wait(15);

    // binary print
    drive_line(1, 1, 0, 999, -1, 0, 10000, 0);
    chk(nsent == 2, "R4 binary line length", nsent, 2);
    check_buf(1, 0, "R3 binary first index");
    idle_wait(12);

    // end-of-record on word 5
    drive_line(1, 0, 0, 999, 5, 0, 10000, 0);
    chk(nsent == 6, "R4 end-of-record closes line", nsent, 6);
    check_buf(0, 0, "R4 eor stored words");
    idle_wait(12);

    // echo, normal addressing
    drive_line(1, 0, 1, 999, -1, 0, 10000, 0);
    check_echo(0);
    check_buf(0, 1, "R6 echo line stored");
    chk(io_check_o == 0, "R8 echo no check", io_check_o, 0);
    chk(rd_time[21] - rd_time[20] == TSH + 1, "R9 echo short step", rd_time[21] - rd_time[20], TSH + 1);
    idle_wait(12);

    // echo with a skipped word
    drive_line(1, 0, 1, 9, -1, 0, 10000, 0);
    chk(io_check_o == 1, "R8 missing word sets check", io_check_o, 1);
    check_buf(0, 1, "R8 stale word stored");
    check_echo(0);
    idle_wait(12);

    // echo, binary addressing; start clears the check flag
    drive_line(1, 1, 1, 999, -1, 0, 10000, 0);
    chk(io_check_o == 0, "R2 R8 start clears check", io_check_o, 0);
    check_echo(1);
    check_buf(1, 1, "R6 binary echo stored");
    idle_wait(12);

    // random mode mix
    for (int n = 0; n < 4; n++) begin
      bit b, e;
      b = 1'($urandom() % 2);
      e = 1'($urandom() % 2);
      drive_line(1, b, e, 999, -1, 0, 10000, 0);
      if (e) check_echo(b);
      else   chk(nsent == (b ? 2 : 24), "R4 random line length", nsent, b ? 2 : 24);
      check_buf(b, e, "R3 R6 random line stored");
      idle_wait(12);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule